// File: doc/BRIEF.md
# SRT Radix-2 Sequential Divider

This block divides one unsigned WIDTH-bit operand by another over a fixed number of clock cycles. It uses the radix-2 SRT method. A pulse on `start_i` captures both operands. The divisor is first scaled left by its leading-zero count, so that its top bit is set, and the dividend's bit pattern is shifted by the same amount into a combined partial-remainder/quotient shift pair. A loop then runs once per quotient bit. In each pass the three most significant bits of the signed partial remainder pick a digit of 0, +1 or -1. A zero digit costs a plain shift with no add or subtract. A +1 digit subtracts the scaled divisor, and a -1 digit adds it.

Positive and negative digits go into two separate vectors. In the closing cycle the negative vector is subtracted from the positive one. If the last partial remainder is negative, the quotient is lowered by one and the divisor is added back to the remainder. The remainder is then shifted right by the scaling amount. The results are registered together with `done_o`, and they stay there until the next accepted start. A zero divisor is outside the block's contract, and its results are unspecified.

Top module: `srt_divider`

## Requirements
- R1: While reset is applied and after it is released, with no start yet, `done_o`, `quotient_o` and `remainder_o` are all zero.
- R2: For any dividend X and nonzero divisor Y, both read as unsigned WIDTH-bit numbers, the result is `quotient_o` = floor(X/Y) and `remainder_o` = X - Y*floor(X/Y). This remainder is always less than Y.
- R3: `done_o` rises exactly WIDTH+1 clock edges after the edge that accepted `start_i`.
- R4: A start that the block accepts while `done_o` is high clears `done_o` on that same edge. `done_o` then stays low until the new result is ready.
- R5: Once a start has been accepted, the block ignores `start_i` and any change of operands until its result is delivered. The delivered result and its latency both belong to the first operands.
- R6: While `done_o` is high and `start_i` stays low, `done_o`, `quotient_o` and `remainder_o` hold their values.
- R7: A divisor whose top bit is already set needs no scaling, and it still gives the R2 result.
- R8: A divisor of 1 needs the maximum scaling of WIDTH-1 places. It gives a quotient equal to the dividend and a remainder of 0.
- R9: A dividend smaller than the divisor gives a quotient of 0, and the remainder equals the dividend.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a division when the block is idle |
| dividend_i | input | WIDTH | Unsigned dividend, sampled on the accepting edge |
| divisor_i | input | WIDTH | Unsigned nonzero divisor, sampled on the accepting edge |
| quotient_o | output | WIDTH | Quotient of the last division |
| remainder_o | output | WIDTH | Remainder of the last division |
| done_o | output | 1 | High while the outputs hold a finished result |

## Verification
A wrong digit choice, a bad scaling amount or a missed correction produces no visible symptom during the loop. It appears only as a wrong quotient or remainder when `done_o` rises, WIDTH+1 cycles after the start. For this reason the operands are varied to force every scaling distance, final remainders of both signs, and both zero and full-scale quotients. An error in the state sequence shows up as a latency other than WIDTH+1, or as outputs that move while they should hold. A separate check follows the internal partial remainder on every loop cycle and flags it the moment it leaves the range from minus the scaled divisor up to the scaled divisor. That catches the error long before the result appears.

// File: rtl/srt_divider.sv
module srt_divider #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [WIDTH-1:0] dividend_i,
  input  logic [WIDTH-1:0] divisor_i,
  output logic [WIDTH-1:0] quotient_o,
  output logic [WIDTH-1:0] remainder_o,
  output logic             done_o
);
  localparam int AW = WIDTH + 1;
  localparam int CW = $clog2(WIDTH + 1);

  typedef enum logic [1:0] {S_IDLE, S_LOOP, S_FIX} state_t;

  state_t           state_r;
  logic [AW-1:0]    a_r;
  logic [WIDTH-1:0] q_r, n_r, b_r;
  logic [CW-1:0]    k_r, cnt_r;

  function automatic logic [CW-1:0] lead_zeros(input logic [WIDTH-1:0] v);
    lead_zeros = CW'(WIDTH);
    for (int i = 0; i < WIDTH; i++)
      if (v[i]) lead_zeros = CW'(WIDTH - 1 - i);
  endfunction

  logic                  idle_w, iter_w;
  logic [CW-1:0]         k_w;
  logic [AW+WIDTH-1:0]   load_w;
  logic [2:0]            top3_w;
  logic                  skip_w, neg_w;
  logic [AW-1:0]         sh_w, step_w, bx_w;
  logic [WIDTH-1:0]      qdiff_w, rfix_w, rden_w;

  assign idle_w  = (state_r == S_IDLE);
  assign iter_w  = (state_r == S_LOOP);
  assign k_w     = lead_zeros(divisor_i);
  assign load_w  = {{AW{1'b0}}, dividend_i} << k_w;

  assign top3_w  = a_r[AW-1 -: 3];
  assign skip_w  = (top3_w == 3'b000) || (top3_w == 3'b111);
  assign neg_w   = a_r[AW-1];
  assign sh_w    = {a_r[AW-2:0], q_r[WIDTH-1]};
  assign bx_w    = {1'b0, b_r};
  assign step_w  = skip_w ? sh_w : (neg_w ? sh_w + bx_w : sh_w - bx_w);

  assign qdiff_w = q_r - n_r;
  assign rfix_w  = neg_w ? a_r[WIDTH-1:0] + b_r : a_r[WIDTH-1:0];
  assign rden_w  = rfix_w >> k_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_r     <= S_IDLE;
      a_r         <= '0;
      q_r         <= '0;
      n_r         <= '0;
      b_r         <= '0;
      k_r         <= '0;
      cnt_r       <= '0;
      quotient_o  <= '0;
      remainder_o <= '0;
      done_o      <= 1'b0;
    end else begin
      case (state_r)
        S_IDLE: if (start_i) begin
          a_r     <= load_w[AW+WIDTH-1:WIDTH];
          q_r     <= load_w[WIDTH-1:0];
          n_r     <= '0;
          b_r     <= divisor_i << k_w;
          k_r     <= k_w;
          cnt_r   <= '0;
          done_o  <= 1'b0;
          state_r <= S_LOOP;
        end
        S_LOOP: begin
          a_r   <= step_w;
          q_r   <= {q_r[WIDTH-2:0], ~skip_w & ~neg_w};
          n_r   <= {n_r[WIDTH-2:0], ~skip_w & neg_w};
          cnt_r <= cnt_r + 1'b1;
          if (cnt_r == CW'(WIDTH - 1)) state_r <= S_FIX;
        end
        S_FIX: begin
          quotient_o  <= neg_w ? qdiff_w - 1'b1 : qdiff_w;
          remainder_o <= rden_w;
          done_o      <= 1'b1;
          state_r     <= S_IDLE;
        end
        default: state_r <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/srt_divider_chk.sv
module srt_divider_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [WIDTH-1:0] dividend_i,
  input logic [WIDTH-1:0] divisor_i,
  input logic [WIDTH-1:0] quotient_o,
  input logic [WIDTH-1:0] remainder_o,
  input logic             done_o,
  input logic             idle_w,
  input logic             iter_w,
  input logic [WIDTH:0]   part_rem,
  input logic [WIDTH-1:0] norm_div
);
  logic             accept;
  logic [WIDTH-1:0] dd_c, dv_c;
  logic [15:0]      lat_c;

  assign accept = start_i && idle_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dd_c  <= '0;
      dv_c  <= '0;
      lat_c <= '0;
    end else if (accept) begin
      dd_c  <= dividend_i;
      dv_c  <= divisor_i;
      lat_c <= '0;
    end else if (lat_c != 16'hFFFF) begin
      lat_c <= lat_c + 16'd1;
    end
  end

  logic [2*WIDTH-1:0]      recon;
  logic signed [WIDTH+1:0] pr_s, d_s;

  assign recon = ({{WIDTH{1'b0}}, quotient_o} * {{WIDTH{1'b0}}, dv_c})
               + {{WIDTH{1'b0}}, remainder_o};
  assign pr_s  = {part_rem[WIDTH], part_rem};
  assign d_s   = {2'b00, norm_div};

  // R2
  quot_rem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> (recon == {{WIDTH{1'b0}}, dd_c}) && (remainder_o < dv_c));

  // R2
  rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iter_w |-> (pr_s < d_s) && (pr_s >= -d_s));

  // R3
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> (lat_c == 16'(WIDTH + 1)));

  // R4
  done_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !done_o);

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o && $stable(quotient_o) && $stable(remainder_o));
endmodule

bind srt_divider srt_divider_chk #(.WIDTH(WIDTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i),
  .dividend_i(dividend_i), .divisor_i(divisor_i),
  .quotient_o(quotient_o), .remainder_o(remainder_o), .done_o(done_o),
  .idle_w(idle_w), .iter_w(iter_w), .part_rem(a_r), .norm_div(b_r)
);

// File: tb/srt_divider_tb_top.sv
`timescale 1ns/1ps
module srt_divider_tb_top;
  localparam int WIDTH = 8;
  localparam int NV = 12;
  localparam int VEC [NV][4] = '{
    '{13, 5, 2, 3},   '{255, 1, 255, 0}, '{255, 255, 1, 0}, '{200, 7, 28, 4},
    '{0, 9, 0, 0},    '{6, 200, 0, 6},   '{128, 128, 1, 0}, '{254, 3, 84, 2},
    '{100, 10, 10, 0},'{77, 129, 0, 77}, '{250, 16, 15, 10},'{199, 13, 15, 4}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [WIDTH-1:0] dividend = '0, divisor = '0;
  logic [WIDTH-1:0] quotient, remainder;
  logic done;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  srt_divider #(.WIDTH(WIDTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .dividend_i(dividend), .divisor_i(divisor),
    .quotient_o(quotient), .remainder_o(remainder), .done_o(done)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic run_div(input int dd, input int dv, input int mid_at,
                         output int q, output int r, output int lat, output int d0);
    @(negedge clk);
    dividend = WIDTH'(dd); divisor = WIDTH'(dv); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    d0 = int'(done);
    lat = 0;
    while (!done && lat < 100) begin
      if (lat == mid_at) begin
        start = 1'b1; dividend = 8'd9; divisor = 8'd3;
      end
      @(negedge clk);
      start = 1'b0;
      lat++;
    end
    q = int'(quotient); r = int'(remainder);
  endtask

  initial begin
    #1ms;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int q, r, lat, d0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(done == 1'b0, "R1 done in reset", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(done == 1'b0, "R1 done after reset", int'(done), 0);
    check(quotient == '0, "R1 quotient after reset", int'(quotient), 0);
    check(remainder == '0, "R1 remainder after reset", int'(remainder), 0);

    // R2 R7 R8 R9: table of vectors
    for (int i = 0; i < NV; i++) begin
      run_div(VEC[i][0], VEC[i][1], -1, q, r, lat, d0);
      check(q == VEC[i][2], "R2 table quotient", q, VEC[i][2]);
      check(r == VEC[i][3], "R2 table remainder", r, VEC[i][3]);
      check(lat == WIDTH + 1, "R3 table latency", lat, WIDTH + 1);
      if (i > 0) check(d0 == 0, "R4 done cleared on start", d0, 0);
    end

    // R7: divisors with top bit set
    for (int i = 0; i < 8; i++) begin
      int dd = (i * 67 + 41) % 256;
      int dv = 128 + i * 15;
      run_div(dd, dv, -1, q, r, lat, d0);
      check(q == dd / dv, "R7 top-bit divisor quotient", q, dd / dv);
      check(r == dd % dv, "R7 top-bit divisor remainder", r, dd % dv);
    end

    // R8: divisor of one
    for (int i = 0; i < 4; i++) begin
      int dd = 255 - i * 71;
      run_div(dd, 1, -1, q, r, lat, d0);
      check(q == dd, "R8 unit divisor quotient", q, dd);
      check(r == 0, "R8 unit divisor remainder", r, 0);
    end

    // R9: dividend below divisor
    run_div(99, 100, -1, q, r, lat, d0);
    check(q == 0, "R9 small dividend quotient", q, 0);
    check(r == 99, "R9 small dividend remainder", r, 99);

    // R2: sweep of computed vectors
    for (int i = 0; i < 300; i++) begin
      int dd = (i * 53 + 17) % 256;
      int dv = ((i * 29) % 255) + 1;
      run_div(dd, dv, -1, q, r, lat, d0);
      check(q == dd / dv, "R2 sweep quotient", q, dd / dv);
      check(r == dd % dv, "R2 sweep remainder", r, dd % dv);
    end

    // R5: start with new operands in the middle of a division
    run_div(200, 7, 3, q, r, lat, d0);
    check(q == 28, "R5 mid-run start quotient", q, 28);
    check(r == 4, "R5 mid-run start remainder", r, 4);
    check(lat == WIDTH + 1, "R5 mid-run start latency", lat, WIDTH + 1);

    // R6: results hold while idle
    dividend = 8'd1; divisor = 8'd1;
    repeat (6) @(negedge clk);
    check(done == 1'b1, "R6 done held", int'(done), 1);
    check(quotient == 8'd28, "R6 quotient held", int'(quotient), 28);
    check(remainder == 8'd4, "R6 remainder held", int'(remainder), 4);

    finish_run();
  end
endmodule